// File: doc/BRIEF.md
# Compare-Match Interval Timer

An up-counting timer of parameterised width (eight bits by default) that advances once per count-enable pulse and works against a writable compare value. One mode bit picks between two behaviours. In free-run mode the counter rolls over at its top value and is restarted only when software writes a new compare value. In restart mode a counter that equals the compare value raises an interrupt request on the following count pulse and is zeroed on that same pulse. The compare value is therefore held for one whole count period, and the interrupt period is the compare value plus one.

The count-enable pulse comes from outside, one system clock wide. A control bit can route it through a register, so that the counter changes one system clock after the raw pulse. This stands in for re-timing an unrelated count source. Software writes one of two registers through a simple write port. Address 0 is the compare value. Address 1 is control, with bit 0 the mode, bit 1 the re-time select and bit 2 a write-one-to-clear bit for the interrupt request. The counter value and the request flag leave the block straight from registers.

Top module: `cmp_timer`

## Requirements
- R1: A synchronous active-high reset clears the counter, the compare value, the mode, the re-time select and the interrupt request flag to zero.
- R2: Each effective count pulse adds one to the counter, and the counter wraps from its maximum value to 0 unless a restart or a clear applies.
- R3: With mode bit (control bit 0) at 0, a write to address 0 zeroes the counter at that clock edge, overriding a count pulse in the same cycle.
- R4: With the mode bit at 1, a write to address 0 updates only the compare value and leaves the counter unchanged.
- R5: With the mode bit at 1, a count pulse that arrives while the counter equals the compare value sets the request flag and zeroes the counter. The interrupt period is therefore the compare value plus one pulses.
- R6: With the mode bit at 0, the request flag never becomes set, even when the counter equals the compare value.
- R7: In restart mode, a compare value below the current counter value is reached only after the counter has wrapped through its maximum to 0.
- R8: Writing address 1 with bit 2 set clears the request flag. A set and a clear in the same cycle leave the flag set.
- R9: With control bit 1 at 1, a count pulse moves the counter one system clock later than with the bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_in | input | 1 | Count-enable pulse, one clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects compare value, 1 selects control |
| wr_data | input | W | Write data |
| count_o | output | W | Counter value |
| irq_o | output | 1 | Interrupt request flag |

## Verification
Two pairs of actions can land on the same clock edge. A software clear of the request flag can meet a restarting count pulse, and a compare write in free-run mode can meet a count pulse. The bench sets up both cases on purpose. It brings the counter to the compare value and then raises the tick together with the clear write, expecting the flag to stay set. It also writes the compare value while ticking in free-run mode, expecting a zero counter. A behavioural model is compared on every clock, and random ticks and writes drive it into further collisions.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int CTL_MODE_BIT = 0;
  localparam int CTL_SYNC_BIT = 1;
  localparam int CTL_ICLR_BIT = 2;

  typedef enum logic {
    ADDR_CMP = 1'b0,
    ADDR_CTL = 1'b1
  } reg_addr_e;

  typedef struct packed {
    logic sync_sel;
    logic restart_mode;
  } ctl_t;
endpackage

// File: rtl/cmp_timer_tick.sv
module cmp_timer_tick #(
  parameter int SYNC_STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_in,
  input  logic sync_sel,
  output logic tick_eff
);
  logic tick_late;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      logic stage_q;
      always_ff @(posedge clk) begin
        if (rst) stage_q <= 1'b0;
        else     stage_q <= tick_in;
      end
      assign tick_late = stage_q;
    end else begin : g_many
      logic [SYNC_STAGES-1:0] shift_q;
      always_ff @(posedge clk) begin
        if (rst) shift_q <= '0;
        else     shift_q <= {shift_q[SYNC_STAGES-2:0], tick_in};
      end
      assign tick_late = shift_q[SYNC_STAGES-1];
    end
  endgenerate

  assign tick_eff = sync_sel ? tick_late : tick_in;
endmodule

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cmp_q,
  output ctl_t         ctl_q,
  output logic         cmp_wr,
  output logic         irq_clr
);
  logic ctl_wr;

  assign cmp_wr  = wr_en && (wr_addr == ADDR_CMP);
  assign ctl_wr  = wr_en && (wr_addr == ADDR_CTL);
  assign irq_clr = ctl_wr && wr_data[CTL_ICLR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      ctl_q <= '0;
    end else begin
      if (cmp_wr) cmp_q <= wr_data;
      if (ctl_wr) begin
        ctl_q.restart_mode <= wr_data[CTL_MODE_BIT];
        ctl_q.sync_sel     <= wr_data[CTL_SYNC_BIT];
      end
    end
  end
endmodule

// File: rtl/cmp_timer_core.sv
module cmp_timer_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         cmp_wr,
  input  logic         restart_mode,
  input  logic [W-1:0] cmp_q,
  output logic [W-1:0] count_q,
  output logic         match_evt
);
  logic         armed;
  logic [W-1:0] count_d;

  // The equality seen now is only acted on at the next count pulse.
  assign armed     = restart_mode && (count_q == cmp_q);
  assign match_evt = tick && armed;

  always_comb begin
    count_d = count_q;
    if (tick) count_d = armed ? '0 : count_q + 1'b1;
    if (cmp_wr && !restart_mode) count_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_d;
  end
endmodule

// File: rtl/cmp_timer_irq.sv
module cmp_timer_irq (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst)        irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;
    else if (clr_i) irq_q <= 1'b0;
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_in,
  input  logic         wr_en,
  input  logic         wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count_o,
  output logic         irq_o
);
  ctl_t         ctl_q;
  logic [W-1:0] cmp_q;
  logic         cmp_wr;
  logic         irq_clr;
  logic         tick_eff;
  logic         match_evt;
  logic         restart_mode;

  assign restart_mode = ctl_q.restart_mode;

  cmp_timer_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmp_q(cmp_q), .ctl_q(ctl_q), .cmp_wr(cmp_wr), .irq_clr(irq_clr)
  );

  cmp_timer_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst(rst), .tick_in(tick_in), .sync_sel(ctl_q.sync_sel),
    .tick_eff(tick_eff)
  );

  cmp_timer_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .tick(tick_eff), .cmp_wr(cmp_wr),
    .restart_mode(restart_mode), .cmp_q(cmp_q),
    .count_q(count_o), .match_evt(match_evt)
  );

  cmp_timer_irq u_irq (
    .clk(clk), .rst(rst), .set_i(match_evt), .clr_i(irq_clr), .irq_q(irq_o)
  );
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         cmp_wr,
  input logic         irq_clr,
  input logic         restart_mode,
  input logic [W-1:0] cmp_q,
  input logic [W-1:0] count_o,
  input logic         irq_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (count_o == '0) && !irq_o);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !(restart_mode && count_o == cmp_q) && !(cmp_wr && !restart_mode))
    |=> count_o == $past(count_o) + 1'b1);

  // R3
  freerun_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_wr && !restart_mode) |=> count_o == '0);

  // R4
  restart_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_wr && restart_mode && !tick) |=> $stable(count_o));

  // R5
  match_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && restart_mode && count_o == cmp_q) |=> irq_o && count_o == '0);

  // R6
  freerun_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!restart_mode && !irq_o) |=> !irq_o);

  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !(tick && restart_mode && count_o == cmp_q)) |=> !irq_o);
endmodule

bind cmp_timer cmp_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick_eff), .cmp_wr(cmp_wr), .irq_clr(irq_clr),
  .restart_mode(restart_mode), .cmp_q(cmp_q), .count_o(count_o), .irq_o(irq_o)
);

// File: tb/cmp_timer_test.sv
`timescale 1ns/1ps
module cmp_timer_test;
  localparam int W    = 8;
  localparam int MODV = 2**W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick_in = 1'b0;
  logic         wr_en = 1'b0;
  logic         wr_addr = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] count_o;
  logic         irq_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit model_on = 1'b0;

  always #4 clk = ~clk;

  cmp_timer #(.W(W)) uut (
    .clk(clk), .rst(rst), .tick_in(tick_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .count_o(count_o), .irq_o(irq_o)
  );

  // Behavioural reference
  int m_cnt, m_cmp;
  bit m_mode, m_sync, m_irq, m_late;

  always @(posedge clk) begin
    bit tk, hit;
    if (rst) begin
      m_cnt = 0; m_cmp = 0; m_mode = 0; m_sync = 0; m_irq = 0; m_late = 0;
    end else begin
      tk  = m_sync ? m_late : tick_in;
      m_late = tick_in;
      hit = m_mode && (m_cnt == m_cmp);
      if (tk) m_cnt = hit ? 0 : (m_cnt + 1) % MODV;
      if (wr_en && !wr_addr && !m_mode) m_cnt = 0;
      if (wr_en && wr_addr && wr_data[2]) m_irq = 0;
      if (tk && hit) m_irq = 1;
      if (wr_en && !wr_addr) m_cmp = wr_data;
      if (wr_en && wr_addr) begin
        m_mode = wr_data[0];
        m_sync = wr_data[1];
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && !rst) begin
      tests++;
      if (count_o !== W'(m_cnt) || irq_o !== m_irq) begin
        fails++;
        $display("FAIL R2/R5 model compare: count=%0d irq=%0b expected count=%0d irq=%0b",
                 count_o, irq_o, m_cnt, m_irq);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge; applies inputs for one clock, returns at next negedge.
  task automatic cyc(input bit tk, input bit we, input bit a, input int d);
    tick_in = tk; wr_en = we; wr_addr = a; wr_data = W'(d);
    @(negedge clk);
    tick_in = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    model_on = 1'b1;
    chk("R1 count after reset", count_o, 0);
    chk("R1 irq after reset", irq_o, 0);

    ticks(10);
    chk("R2 ten pulses", count_o, 10);

    // compare write while ticking in free-run mode: write wins
    cyc(1'b1, 1'b1, 1'b0, 5);
    chk("R3 write clears over tick", count_o, 0);
    ticks(20);
    chk("R6 passed compare, count", count_o, 20);
    chk("R6 no request in free-run", irq_o, 0);
    ticks(236);
    chk("R2 wrap to zero", count_o, 0);
    chk("R6 no request after wrap", irq_o, 0);

    // setup: zero counter, then to 10
    cyc(1'b0, 1'b1, 1'b0, 200);
    ticks(10);
    cyc(1'b0, 1'b1, 1'b1, 1);        // restart mode
    cyc(1'b0, 1'b1, 1'b0, 3);        // compare 3, below counter
    chk("R4 counter kept on compare write", count_o, 10);
    ticks(249);
    chk("R7 reached compare after wrap", count_o, 3);
    chk("R7 no request yet", irq_o, 0);
    repeat (3) cyc(1'b0, 1'b0, 1'b0, 0);
    chk("R5 value held while idle", count_o, 3);
    ticks(1);
    chk("R5 restart count", count_o, 0);
    chk("R5 request set", irq_o, 1);

    cyc(1'b0, 1'b1, 1'b1, 5);        // clear, keep restart mode
    chk("R8 clear request", irq_o, 0);
    ticks(3);
    chk("R5 period step count", count_o, 3);
    chk("R5 no early request", irq_o, 0);
    ticks(1);
    chk("R5 period cmp+1 request", irq_o, 1);
    cyc(1'b0, 1'b1, 1'b1, 5);
    ticks(3);
    cyc(1'b1, 1'b1, 1'b1, 5);        // set and clear together
    chk("R8 set wins over clear", irq_o, 1);
    chk("R8 counter restarted", count_o, 0);

    // re-timed count pulse
    cyc(1'b0, 1'b1, 1'b1, 3);        // restart + sync
    cyc(1'b1, 1'b0, 1'b0, 0);
    chk("R9 no move on raw edge", count_o, 0);
    cyc(1'b0, 1'b0, 1'b0, 0);
    chk("R9 move one clock later", count_o, 1);
    cyc(1'b0, 1'b1, 1'b1, 1);        // back to direct, restart mode
    cyc(1'b1, 1'b0, 1'b0, 0);
    chk("R9 direct pulse moves at once", count_o, 2);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3)
        cyc($urandom_range(0, 1) == 1, 1'b1, 1'b1, $urandom_range(0, 7));
      else if (r < 6)
        cyc($urandom_range(0, 1) == 1, 1'b1, 1'b0, $urandom_range(0, 12));
      else
        cyc($urandom_range(0, 2) != 0, 1'b0, 1'b0, 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule